// File: doc/BRIEF.md
# Tapped Binary Frequency Divider

This block divides an oscillator clock through a chain of fourteen divide-by-two stages and brings out ten of those stages as divided clocks. The chain advances on the falling edge of the input clock. Stages one to three and stage eleven stay internal. Stage n toggles at half the rate of stage n-1, so it repeats every 2^n input cycles.

An asynchronous active-low reset clears every stage and forces all outputs low, whatever the clock does. While reset is held, the block also drops an enable output. That output lets the external oscillator stop for low-power standby.

Stage outputs in a real ripple chain do not settle together. For that reason, a decode of several taps is offered only while the input clock is high. In that half of the period the count cannot move, because it changes on the falling edge. The decode compares the tap vector against a pattern input. A parameter can remove the decode.

Top module: `tap_ripple_div`

## Requirements
- R1: The internal count runs modulo 16384. From state 16383, where all ten taps read 1, the next falling edge returns it to state 0, where all ten taps read 0.
- R2: With rst_ni high, each falling edge of clk_i advances the count by exactly one. A rising edge leaves every output unchanged.
- R3: While rst_ni is low, tap_o is all zeros and decode_o is 0. This holds at once, with no clock edge needed, including when reset arrives in the middle of a count.
- R4: osc_en_o is 0 while rst_ni is low and 1 while rst_ni is high.
- R5: Stage n is count bit n-1. tap_o[0] through tap_o[6] carry stages 4 through 10. tap_o[7], tap_o[8] and tap_o[9] carry stages 12, 13 and 14.
- R6: Tap for stage n has a period of 2^n input cycles: 16 for tap_o[0], 1024 for tap_o[6] and 16384 for tap_o[9].
- R7: After reset is released, the first falling edge moves the count from 0 to 1. tap_o[0] therefore first rises on the eighth falling edge.
- R8: decode_o is 1 only when rst_ni is high, clk_i is high and tap_o equals match_pat_i bit for bit. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock; count advances on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_pat_i | input | 10 | Tap pattern compared by the decode |
| osc_en_o | output | 1 | Oscillator run enable, low during reset |
| tap_o | output | 10 | Selected stage outputs (stages 4-10, 12-14) |
| decode_o | output | 1 | Pattern match qualified by clk_i high |

## Verification
A counter that advanced on the rising edge would show its taps changing half a period early, against a model that moves only on falling edges. A design that skipped or doubled the first edge after release would raise tap_o[0] one edge off from the eighth. Reset is dropped in the middle of a count, between edges: a synchronous reset would leave stale taps in place until the next edge, and a missing enable gate would keep the oscillator running. The run covers a full wrap and measures the period of the highest tap. It moves the decode pattern through several values and checks that decode_o never shows up in the low clock phase, which is where a spike from an unqualified decode would appear.

// File: rtl/tap_div_pkg.sv
package tap_div_pkg;
  // maps tap index to stage number (1-based), skipping one internal stage
  function automatic int unsigned tap_stage(int unsigned idx, int unsigned first,
                                            int unsigned skip);
    int unsigned s;
    s = idx + first;
    if (s >= skip) s = s + 1;
    return s;
  endfunction
endpackage

// File: rtl/div_stage.sv
module div_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (tog_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/stage_chain.sv
module stage_chain #(
  parameter int unsigned STAGES = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] tog_i,
  output logic [STAGES-1:0] q_o
);
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    div_stage u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tog_i (tog_i[k]),
      .q_o   (q_o[k])
    );
  end
endmodule

// File: rtl/tap_route.sv
module tap_route #(
  parameter int unsigned STAGES     = 14,
  parameter int unsigned NUM_TAPS   = 10,
  parameter int unsigned FIRST_TAP  = 4,
  parameter int unsigned SKIP_STAGE = 11
) (
  input  logic [STAGES-1:0]   stage_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  import tap_div_pkg::*;
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int unsigned SBIT = tap_stage(i, FIRST_TAP, SKIP_STAGE) - 1;
    assign tap_o[i] = stage_i[SBIT];
  end
endmodule

// File: rtl/phase_decode.sv
module phase_decode #(
  parameter int unsigned NUM_TAPS  = 10,
  parameter bit          DECODE_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic [NUM_TAPS-1:0] pat_i,
  output logic                decode_o
);
  if (DECODE_EN) begin : g_dec
    // taps only move on the falling edge, so the high phase is spike-free
    assign decode_o = clk_i & rst_ni & (tap_i == pat_i);
  end else begin : g_nodec
    assign decode_o = 1'b0;
  end
endmodule

// File: rtl/tap_ripple_div.sv
module tap_ripple_div #(
  parameter int unsigned STAGES     = 14,
  parameter int unsigned NUM_TAPS   = 10,
  parameter int unsigned FIRST_TAP  = 4,
  parameter int unsigned SKIP_STAGE = 11,
  parameter bit          DECODE_EN  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] match_pat_i,
  output logic                osc_en_o,
  output logic [NUM_TAPS-1:0] tap_o,
  output logic                decode_o
);
  logic [STAGES-1:0] count_w;
  logic [STAGES-1:0] tog_w;

  // toggle enable: a stage flips when every lower stage is set
  assign tog_w[0] = 1'b1;
  for (genvar k = 1; k < STAGES; k++) begin : g_tog
    assign tog_w[k] = tog_w[k-1] & count_w[k-1];
  end

  stage_chain #(.STAGES(STAGES)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tog_i (tog_w),
    .q_o   (count_w)
  );

  tap_route #(
    .STAGES    (STAGES),
    .NUM_TAPS  (NUM_TAPS),
    .FIRST_TAP (FIRST_TAP),
    .SKIP_STAGE(SKIP_STAGE)
  ) u_route (
    .stage_i(count_w),
    .tap_o  (tap_o)
  );

  phase_decode #(
    .NUM_TAPS (NUM_TAPS),
    .DECODE_EN(DECODE_EN)
  ) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tap_i   (tap_o),
    .pat_i   (match_pat_i),
    .decode_o(decode_o)
  );

  assign osc_en_o = rst_ni;
endmodule

// File: rtl/tap_ripple_div_chk.sv
module tap_ripple_div_chk #(
  parameter int unsigned STAGES     = 14,
  parameter int unsigned NUM_TAPS   = 10,
  parameter int unsigned FIRST_TAP  = 4,
  parameter int unsigned SKIP_STAGE = 11
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_TAPS-1:0] match_pat_i,
  input logic                osc_en_o,
  input logic [NUM_TAPS-1:0] tap_o,
  input logic                decode_o,
  input logic [STAGES-1:0]   count_i
);
  import tap_div_pkg::*;

  // R3
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (tap_o == '0 && !decode_o));

  // R4
  osc_off_chk: assert property (@(posedge clk_i) !rst_ni |-> !osc_en_o);

  // R4
  osc_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) osc_en_o);

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i == STAGES'($past(count_i) + 1'b1));

  // R1
  count_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '1) |=> (count_i == '0));

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_map
    localparam int unsigned SBIT = tap_stage(i, FIRST_TAP, SKIP_STAGE) - 1;
    // R5
    tap_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_o[i] == count_i[SBIT]);
  end

  // R8
  decode_hi_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    decode_o == (tap_o == match_pat_i));

  // R8
  decode_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !decode_o);
endmodule

bind tap_ripple_div tap_ripple_div_chk #(
  .STAGES    (STAGES),
  .NUM_TAPS  (NUM_TAPS),
  .FIRST_TAP (FIRST_TAP),
  .SKIP_STAGE(SKIP_STAGE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .match_pat_i(match_pat_i),
  .osc_en_o   (osc_en_o),
  .tap_o      (tap_o),
  .decode_o   (decode_o),
  .count_i    (count_w)
);

// File: tb/tap_ripple_div_tb.sv
`timescale 1ns/1ps
module tap_ripple_div_tb;
  localparam int MODV = 16384;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [9:0] match_pat_i = '0;
  logic       osc_en_o;
  logic [9:0] tap_o;
  logic       decode_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  chk_on  = 0;
  bit  meas_on = 0;
  bit  saw_full = 0;
  bit  saw_wrap = 0;
  int  hits = 0;
  int  ref_cnt = 0;
  int  prev_ref = 0;
  time t_prev [3];
  int  per    [3];
  bit  done   = 0;

  tap_ripple_div u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .match_pat_i(match_pat_i),
    .osc_en_o   (osc_en_o),
    .tap_o      (tap_o),
    .decode_o   (decode_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [9:0] exp_taps(int c);
    logic [9:0] t;
    for (int i = 0; i < 10; i++) begin
      int st;
      st = (i < 7) ? i + 4 : i + 5;
      t[i] = ((c >> (st - 1)) & 1) != 0;
    end
    return t;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference count
  always @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_cnt <= 0;
    else         ref_cnt <= (ref_cnt + 1) % MODV;
  end

  // high phase: taps, decode, enable
  always @(posedge clk_i) begin
    #2;
    if (chk_on && !done) begin
      chk(tap_o == exp_taps(ref_cnt), (ref_cnt == 0 || ref_cnt == MODV-1) ? "R1" : "R5",
          tap_o, exp_taps(ref_cnt));
      chk(decode_o == (rst_ni && exp_taps(ref_cnt) == match_pat_i), "R8", decode_o,
          rst_ni && exp_taps(ref_cnt) == match_pat_i);
      chk(osc_en_o == rst_ni, "R4", osc_en_o, rst_ni);
      if (decode_o) hits++;
      if (rst_ni && ref_cnt == MODV-1 && tap_o == 10'h3FF) saw_full = 1;
      if (rst_ni && saw_full && prev_ref == MODV-1 && ref_cnt == 0 && tap_o == '0) saw_wrap = 1;
      prev_ref = ref_cnt;
    end
  end

  // low phase: taps only moved on the falling edge, decode must be quiet
  always @(negedge clk_i) begin
    #2;
    if (chk_on && !done) begin
      chk(tap_o == exp_taps(ref_cnt), "R2", tap_o, exp_taps(ref_cnt));
      chk(decode_o == 1'b0, "R8", decode_o, 0);
    end
  end

  always @(posedge tap_o[0]) if (meas_on) begin
    if (t_prev[0] != 0) per[0] = int'(($time - t_prev[0]) / 20);
    t_prev[0] = $time;
  end
  always @(posedge tap_o[6]) if (meas_on) begin
    if (t_prev[1] != 0) per[1] = int'(($time - t_prev[1]) / 20);
    t_prev[1] = $time;
  end
  always @(posedge tap_o[9]) if (meas_on) begin
    if (t_prev[2] != 0) per[2] = int'(($time - t_prev[2]) / 20);
    t_prev[2] = $time;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 3; i++) begin t_prev[i] = 0; per[i] = 0; end
    #1 rst_ni = 1'b0;
    #2 chk_on = 1;
    // R3 R4: reset state before any clock edge
    chk(tap_o == '0, "R3", tap_o, 0);
    chk(decode_o == 1'b0, "R3", decode_o, 0);
    chk(osc_en_o == 1'b0, "R4", osc_en_o, 0);
    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1'b1;
    // R7: tap_o[0] first rises on the eighth falling edge
    n = 0;
    while (tap_o[0] == 1'b0 && n < 20) begin
      @(negedge clk_i); #3; n++;
    end
    chk(n == 8, "R7", n, 8);
    repeat (37) @(negedge clk_i);
    // R3 R4: asynchronous reset in the middle of a count
    #5 rst_ni = 1'b0;
    #1;
    chk(tap_o == '0, "R3", tap_o, 0);
    chk(decode_o == 1'b0, "R3", decode_o, 0);
    chk(osc_en_o == 1'b0, "R4", osc_en_o, 0);
    repeat (2) @(negedge clk_i);
    #2;
    chk(tap_o == '0, "R3", tap_o, 0);
    @(posedge clk_i);
    #3 rst_ni = 1'b1;
    meas_on = 1;
    repeat (5000) @(negedge clk_i);
    #5 match_pat_i = 10'h2AA;
    repeat (5000) @(negedge clk_i);
    #5 match_pat_i = 10'h3FF;
    repeat (16000) @(negedge clk_i);
    #5;
    // R6: tap periods in input cycles
    chk(per[0] == 16, "R6", per[0], 16);
    chk(per[1] == 1024, "R6", per[1], 1024);
    chk(per[2] == 16384, "R6", per[2], 16384);
    // R1: passed through 16383 and wrapped to 0
    chk(saw_full, "R1", saw_full, 1);
    chk(saw_wrap, "R1", saw_wrap, 1);
    // R8: decode fired for matching patterns
    chk(hits > 0, "R8", hits, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule